// File: doc/BRIEF.md
# Byte ALU with Register File and Flag Write-Back

This block is the execute stage for the register-to-register arithmetic and logic instructions of a small 8-bit interpreter-style processor. It contains a file of sixteen byte registers. The highest register doubles as the flag register. A caller presents an operation selector and two register indices, then pulses `start`. On the next clock edge the block reads both operands and computes the result. It writes the result into the first-named register, then updates the flag register. It also raises `done` for one cycle.

Two configuration inputs choose between the legacy and the modern behaviour. One picks the shift source register. The other chooses whether the bitwise operations leave the flag register alone or clear it. When both the result and the flag target the flag register, the flag wins. A byte load port lets the surrounding pipeline place operand values, such as memory loads or immediate loads, into the file. A combinational peek port reads any register.

Top module: `byte_alu_core`

## Requirements
- R1: Selector 0x0 copies Vy into Vx and leaves VF unchanged when x is not 15.
- R2: Selectors 0x1, 0x2 and 0x3 write Vx|Vy, Vx&Vy and Vx^Vy into Vx. When `logic_keep_flag` is high, VF is left unchanged.
- R3: When `logic_keep_flag` is low, the three bitwise selectors write 0x00 into VF after the result.
- R4: Selector 0x4 writes (Vx+Vy) mod 256 into Vx. It writes 0x01 into VF on a carry out of bit 7 and 0x00 otherwise.
- R5: Selector 0x5 writes (Vx-Vy) mod 256 into Vx. VF becomes 0x01 when Vx >= Vy, which means no borrow, and 0x00 otherwise.
- R6: Selector 0x7 writes (Vy-Vx) mod 256 into Vx. VF becomes 0x01 when Vy >= Vx and 0x00 otherwise.
- R7: Selector 0x6 writes the source shifted right by one, with bit 7 zero, into Vx. VF becomes 0x0 followed by the old bit 0 of the source.
- R8: Selector 0xE writes the source shifted left by one, with bit 0 zero, into Vx. VF becomes 0x0 followed by the old bit 7 of the source.
- R9: The shift source is Vy when `shift_inplace` is low and Vx when it is high.
- R10: When x is 15, every selector that writes a flag leaves the flag value in VF rather than the result.
- R11: `done` is high in exactly the cycle after a cycle with `start` high. An operation changes no register other than Vx and VF.
- R12: Selectors 0x8 to 0xD and 0xF change no register and still pulse `done`.
- R13: A synchronous active-high `rst` clears all sixteen registers to 0x00 and clears `done`.
- R14: `load_en` writes `load_data` into register `load_idx` when `start` is low. The load is ignored when `start` is high. With neither input high, no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Execute the selected operation this cycle |
| op_sel | input | 4 | Operation selector |
| x_idx | input | 4 | Index of first operand and destination |
| y_idx | input | 4 | Index of second operand |
| shift_inplace | input | 1 | 1: shift Vx; 0: shift Vy into Vx |
| logic_keep_flag | input | 1 | 1: bitwise ops leave VF; 0: they clear it |
| load_en | input | 1 | External byte write strobe |
| load_idx | input | 4 | External write register index |
| load_data | input | 8 | External write data |
| peek_idx | input | 4 | Register index to observe |
| peek_data | output | 8 | Current contents of register peek_idx |
| done | output | 1 | Completion pulse, one cycle after start |

## Verification
Every register update lands on the edge that samples `start`. A wrong result, a lost carry or borrow, or a wrong shift source therefore shows up on the peek port in the very next cycle. The bench reads back all sixteen registers after each operation. This exposes a wrong flag priority when x is 15, and it also exposes a stray write to a neighbouring register. An undefined selector or an ignored load that alters state is caught the same way, in the cycle right after the stimulus.

// File: rtl/byte_alu_pkg.sv
package byte_alu_pkg;

    localparam int OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_COPY = 4'h0,
        OP_OR   = 4'h1,
        OP_AND  = 4'h2,
        OP_XOR  = 4'h3,
        OP_ADD  = 4'h4,
        OP_SUB  = 4'h5,
        OP_SHR  = 4'h6,
        OP_RSUB = 4'h7,
        OP_SHL  = 4'hE
    } alu_op_e;

    function automatic logic op_is_defined(input logic [OP_W-1:0] op);
        return (op <= 4'h7) || (op == 4'hE);
    endfunction

    function automatic logic op_is_bitwise(input logic [OP_W-1:0] op);
        return (op == 4'h1) || (op == 4'h2) || (op == 4'h3);
    endfunction

endpackage

// File: rtl/byte_alu_regfile.sv
module byte_alu_regfile #(
    parameter int NREG = 16,
    parameter int DW   = 8,
    localparam int IW  = $clog2(NREG)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               a_we,
    input  logic [IW-1:0]      a_idx,
    input  logic [DW-1:0]      a_data,
    input  logic               f_we,
    input  logic [IW-1:0]      f_idx,
    input  logic [DW-1:0]      f_data,
    input  logic [IW-1:0]      rx_idx,
    output logic [DW-1:0]      rx_data,
    input  logic [IW-1:0]      ry_idx,
    output logic [DW-1:0]      ry_data,
    input  logic [IW-1:0]      rp_idx,
    output logic [DW-1:0]      rp_data,
    output logic [NREG*DW-1:0] flat
);

    logic [DW-1:0] regs [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                regs[g] <= '0;
            end else if (f_we && (f_idx == IW'(g))) begin
                regs[g] <= f_data;          // flag port has priority
            end else if (a_we && (a_idx == IW'(g))) begin
                regs[g] <= a_data;
            end
        end
        assign flat[g*DW +: DW] = regs[g];
    end

    assign rx_data = regs[rx_idx];
    assign ry_data = regs[ry_idx];
    assign rp_data = regs[rp_idx];

endmodule

// File: rtl/byte_alu_exec.sv
module byte_alu_exec
    import byte_alu_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic [OP_W-1:0] op_sel,
    input  logic [DW-1:0]   vx,
    input  logic [DW-1:0]   vy,
    input  logic            shift_inplace,
    input  logic            logic_keep_flag,
    output logic [DW-1:0]   res,
    output logic            res_we,
    output logic            flag,
    output logic            flag_we
);

    logic [DW:0]   sum_ext;
    logic [DW-1:0] shift_src;

    assign sum_ext   = {1'b0, vx} + {1'b0, vy};
    assign shift_src = shift_inplace ? vx : vy;

    always_comb begin
        res     = '0;
        res_we  = 1'b1;
        flag    = 1'b0;
        flag_we = 1'b1;
        case (alu_op_e'(op_sel))
            OP_COPY: begin
                res     = vy;
                flag_we = 1'b0;
            end
            OP_OR: begin
                res     = vx | vy;
                flag_we = !logic_keep_flag;
            end
            OP_AND: begin
                res     = vx & vy;
                flag_we = !logic_keep_flag;
            end
            OP_XOR: begin
                res     = vx ^ vy;
                flag_we = !logic_keep_flag;
            end
            OP_ADD: begin
                res  = sum_ext[DW-1:0];
                flag = sum_ext[DW];
            end
            OP_SUB: begin
                res  = vx - vy;
                flag = (vx >= vy);
            end
            OP_RSUB: begin
                res  = vy - vx;
                flag = (vy >= vx);
            end
            OP_SHR: begin
                res  = {1'b0, shift_src[DW-1:1]};
                flag = shift_src[0];
            end
            OP_SHL: begin
                res  = {shift_src[DW-2:0], 1'b0};
                flag = shift_src[DW-1];
            end
            default: begin
                res_we  = 1'b0;
                flag_we = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/byte_alu_core.sv
module byte_alu_core
    import byte_alu_pkg::*;
#(
    parameter int NREG = 16,
    parameter int DW   = 8,
    localparam int IW  = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [OP_W-1:0] op_sel,
    input  logic [IW-1:0]   x_idx,
    input  logic [IW-1:0]   y_idx,
    input  logic            shift_inplace,
    input  logic            logic_keep_flag,
    input  logic            load_en,
    input  logic [IW-1:0]   load_idx,
    input  logic [DW-1:0]   load_data,
    input  logic [IW-1:0]   peek_idx,
    output logic [DW-1:0]   peek_data,
    output logic            done
);

    localparam logic [IW-1:0] FLAG_IDX = IW'(NREG - 1);

    logic [DW-1:0]      vx, vy, alu_res;
    logic               alu_res_we, alu_flag, alu_flag_we;
    logic               a_we, f_we;
    logic [IW-1:0]      a_idx;
    logic [DW-1:0]      a_data, f_data;
    logic [NREG*DW-1:0] regs_flat;

    byte_alu_exec #(.DW(DW)) u_exec (
        .op_sel          (op_sel),
        .vx              (vx),
        .vy              (vy),
        .shift_inplace   (shift_inplace),
        .logic_keep_flag (logic_keep_flag),
        .res             (alu_res),
        .res_we          (alu_res_we),
        .flag            (alu_flag),
        .flag_we         (alu_flag_we)
    );

    // result/load share the main write port; start owns it when present
    always_comb begin
        if (start) begin
            a_we   = alu_res_we;
            a_idx  = x_idx;
            a_data = alu_res;
        end else begin
            a_we   = load_en;
            a_idx  = load_idx;
            a_data = load_data;
        end
    end

    assign f_we   = start && alu_flag_we;
    assign f_data = {{(DW-1){1'b0}}, alu_flag};

    byte_alu_regfile #(.NREG(NREG), .DW(DW)) u_rf (
        .clk     (clk),
        .rst     (rst),
        .a_we    (a_we),
        .a_idx   (a_idx),
        .a_data  (a_data),
        .f_we    (f_we),
        .f_idx   (FLAG_IDX),
        .f_data  (f_data),
        .rx_idx  (x_idx),
        .rx_data (vx),
        .ry_idx  (y_idx),
        .ry_data (vy),
        .rp_idx  (peek_idx),
        .rp_data (peek_data),
        .flat    (regs_flat)
    );

    always_ff @(posedge clk) begin
        if (rst) done <= 1'b0;
        else     done <= start;
    end

endmodule

// File: rtl/byte_alu_checker.sv
module byte_alu_checker
    import byte_alu_pkg::*;
#(
    parameter int NREG = 16,
    parameter int DW   = 8,
    localparam int IW  = $clog2(NREG)
) (
    input logic               clk,
    input logic               rst,
    input logic               start,
    input logic [OP_W-1:0]    op_sel,
    input logic [IW-1:0]      x_idx,
    input logic [IW-1:0]      y_idx,
    input logic               logic_keep_flag,
    input logic               load_en,
    input logic               done,
    input logic [NREG*DW-1:0] regs_flat
);

    localparam int FLAG = NREG - 1;

    logic [DW-1:0]      vx_q, vy_q;
    logic [DW:0]        sum_q;
    logic [NREG*DW-1:0] prev_q, mask_now, mask_q;

    always_comb begin
        mask_now = '1;
        mask_now[x_idx*DW +: DW] = '0;
        mask_now[FLAG*DW +: DW]  = '0;
    end

    always_ff @(posedge clk) begin
        vx_q   <= regs_flat[x_idx*DW +: DW];
        vy_q   <= regs_flat[y_idx*DW +: DW];
        prev_q <= regs_flat;
        mask_q <= mask_now;
    end

    assign sum_q = {1'b0, vx_q} + {1'b0, vy_q};

    assert_done_R11: assert property (@(posedge clk) disable iff (rst)
        start |=> done);
    assert_no_done_R11: assert property (@(posedge clk) disable iff (rst)
        !start |=> !done);
    assert_others_kept_R11: assert property (@(posedge clk) disable iff (rst)
        start |=> (((regs_flat ^ prev_q) & mask_q) == '0));
    assert_undef_R12: assert property (@(posedge clk) disable iff (rst)
        (start && !op_is_defined(op_sel)) |=> $stable(regs_flat));
    assert_clear_flag_R3: assert property (@(posedge clk) disable iff (rst)
        (start && op_is_bitwise(op_sel) && !logic_keep_flag)
            |=> (regs_flat[FLAG*DW +: DW] == '0));
    assert_add_carry_R4: assert property (@(posedge clk) disable iff (rst)
        (start && op_sel == OP_ADD)
            |=> (regs_flat[FLAG*DW +: DW] == {{(DW-1){1'b0}}, sum_q[DW]}));
    assert_quiet_R14: assert property (@(posedge clk) disable iff (rst)
        (!start && !load_en) |=> $stable(regs_flat));

endmodule

bind byte_alu_core byte_alu_checker #(.NREG(NREG), .DW(DW)) u_chk (
    .clk             (clk),
    .rst             (rst),
    .start           (start),
    .op_sel          (op_sel),
    .x_idx           (x_idx),
    .y_idx           (y_idx),
    .logic_keep_flag (logic_keep_flag),
    .load_en         (load_en),
    .done            (done),
    .regs_flat       (regs_flat)
);

// File: tb/sim_byte_alu_core.sv
`timescale 1ns/1ps
module sim_byte_alu_core;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [3:0] op_sel = '0;
    logic [3:0] x_idx = '0;
    logic [3:0] y_idx = '0;
    logic       shift_inplace = 1'b0;
    logic       logic_keep_flag = 1'b0;
    logic       load_en = 1'b0;
    logic [3:0] load_idx = '0;
    logic [7:0] load_data = '0;
    logic [3:0] peek_idx = '0;
    logic [7:0] peek_data;
    logic       done;

    int total = 0;
    int bad   = 0;
    logic [7:0] m [16];

    always #2.5 clk = ~clk;

    byte_alu_core u0 (
        .clk(clk), .rst(rst), .start(start), .op_sel(op_sel),
        .x_idx(x_idx), .y_idx(y_idx), .shift_inplace(shift_inplace),
        .logic_keep_flag(logic_keep_flag), .load_en(load_en),
        .load_idx(load_idx), .load_data(load_data),
        .peek_idx(peek_idx), .peek_data(peek_data), .done(done)
    );

    task automatic check(input string req, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%02h expected=%02h", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        for (int i = 0; i < 16; i++) begin
            peek_idx = 4'(i);
            #0.05;
            check(req, $sformatf("V%0d", i), peek_data, m[i]);
        end
    endtask

    function automatic string tag_of(input logic [3:0] op, input logic [3:0] x,
                                     input logic inpl, input logic keep);
        if (x == 4'hF && (op == 4'h4 || op == 4'h5 || op == 4'h6 ||
                          op == 4'h7 || op == 4'hE)) return "R10";
        case (op)
            4'h0: return "R1";
            4'h1, 4'h2, 4'h3: return keep ? "R2" : "R3";
            4'h4: return "R4";
            4'h5: return "R5";
            4'h7: return "R6";
            4'h6: return inpl ? "R7" : "R9";
            4'hE: return inpl ? "R8" : "R9";
            default: return "R12";
        endcase
    endfunction

    task automatic model_op(input logic [3:0] op, input logic [3:0] x,
                            input logic [3:0] y, input logic inpl, input logic keep);
        logic [7:0] vx = m[x];
        logic [7:0] vy = m[y];
        logic [7:0] src = inpl ? vx : vy;
        logic [7:0] r = '0;
        logic f = 1'b0;
        logic wr = 1'b1;
        logic fw = 1'b1;
        case (op)
            4'h0: begin r = vy; fw = 1'b0; end
            4'h1: begin r = vx | vy; fw = !keep; end
            4'h2: begin r = vx & vy; fw = !keep; end
            4'h3: begin r = vx ^ vy; fw = !keep; end
            4'h4: begin r = vx + vy; f = (int'(vx) + int'(vy)) > 255; end
            4'h5: begin r = vx - vy; f = (vx >= vy); end
            4'h7: begin r = vy - vx; f = (vy >= vx); end
            4'h6: begin r = src >> 1; f = src[0]; end
            4'hE: begin r = src << 1; f = src[7]; end
            default: begin wr = 1'b0; fw = 1'b0; end
        endcase
        if (wr) m[x] = r;
        if (fw) m[15] = {7'b0, f};
    endtask

    task automatic do_load(input logic [3:0] idx, input logic [7:0] val);
        @(negedge clk);
        load_en = 1'b1; load_idx = idx; load_data = val;
        @(negedge clk);
        load_en = 1'b0;
        m[idx] = val;
    endtask

    task automatic do_op(input logic [3:0] op, input logic [3:0] x,
                         input logic [3:0] y, input logic inpl, input logic keep,
                         input logic also_load);
        string t = tag_of(op, x, inpl, keep);
        @(negedge clk);
        start = 1'b1; op_sel = op; x_idx = x; y_idx = y;
        shift_inplace = inpl; logic_keep_flag = keep;
        if (also_load) begin
            load_en = 1'b1; load_idx = 4'h3; load_data = 8'h5A;
        end
        @(negedge clk);
        start = 1'b0; load_en = 1'b0;
        model_op(op, x, y, inpl, keep);
        check("R11", "done after start", {7'b0, done}, 8'h01);
        check_all(also_load ? "R14" : t);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 16; i++) m[i] = '0;
        check("R13", "done in reset", {7'b0, done}, 8'h00);
        check_all("R13");
    endtask

    initial begin
        #200000;
        bad++; total++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 16; i++) m[i] = '0;
        @(negedge clk);
        do_reset();
        // R14 loads and idle
        do_load(4'h1, 8'hFF);
        do_load(4'h2, 8'h01);
        check_all("R14");
        @(negedge clk);
        check("R11", "no done when idle", {7'b0, done}, 8'h00);
        // R4 carry and no carry
        do_op(4'h4, 4'h1, 4'h2, 1'b0, 1'b0, 1'b0);   // FF+01 -> 00, VF=1
        do_load(4'h4, 8'h80); do_load(4'h5, 8'h7F);
        do_op(4'h4, 4'h4, 4'h5, 1'b0, 1'b0, 1'b0);   // FF, VF=0
        // R5/R6 equal operands and borrow
        do_load(4'h6, 8'h33); do_load(4'h7, 8'h33);
        do_op(4'h5, 4'h6, 4'h7, 1'b0, 1'b0, 1'b0);
        do_load(4'h6, 8'h10);
        do_op(4'h5, 4'h6, 4'h7, 1'b0, 1'b0, 1'b0);
        do_load(4'h6, 8'h40);
        do_op(4'h7, 4'h6, 4'h7, 1'b0, 1'b0, 1'b0);
        do_load(4'h6, 8'h20);
        do_op(4'h7, 4'h6, 4'h7, 1'b0, 1'b0, 1'b0);
        // R7/R8/R9 shift sources
        do_load(4'h8, 8'h81); do_load(4'h9, 8'h42);
        do_op(4'h6, 4'h8, 4'h9, 1'b1, 1'b0, 1'b0);
        do_load(4'h8, 8'h81);
        do_op(4'h6, 4'h8, 4'h9, 1'b0, 1'b0, 1'b0);
        do_load(4'h8, 8'h81);
        do_op(4'hE, 4'h8, 4'h9, 1'b1, 1'b0, 1'b0);
        do_load(4'h8, 8'h81);
        do_op(4'hE, 4'h8, 4'h9, 1'b0, 1'b0, 1'b0);
        // R2/R3 flag behaviour of bitwise ops
        do_load(4'hF, 8'h77);
        do_op(4'h1, 4'h9, 4'h8, 1'b0, 1'b1, 1'b0);
        do_op(4'h3, 4'h9, 4'h8, 1'b0, 1'b0, 1'b0);
        // R1 copy keeps VF
        do_load(4'hF, 8'h66);
        do_op(4'h0, 4'hA, 4'h9, 1'b0, 1'b0, 1'b0);
        // R10 flag over result
        do_load(4'hF, 8'hF0); do_load(4'hB, 8'h20);
        do_op(4'h4, 4'hF, 4'hB, 1'b0, 1'b0, 1'b0);
        do_load(4'hF, 8'h03);
        do_op(4'h6, 4'hF, 4'hB, 1'b1, 1'b0, 1'b0);
        // R12 undefined selectors
        do_op(4'h8, 4'h1, 4'h2, 1'b0, 1'b0, 1'b0);
        do_op(4'hF, 4'hF, 4'h2, 1'b0, 1'b0, 1'b0);
        // R14 load ignored under start
        do_op(4'h0, 4'h1, 4'h2, 1'b0, 1'b0, 1'b1);
        // random mix
        for (int k = 0; k < 400; k++) begin
            if ($urandom_range(0, 3) == 0)
                do_load(4'($urandom_range(0, 15)), 8'($urandom));
            else
                do_op(4'($urandom_range(0, 15)), 4'($urandom_range(0, 15)),
                      4'($urandom_range(0, 15)), 1'($urandom), 1'($urandom), 1'b0);
        end
        do_reset();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule